// File: doc/BRIEF.md
# Ones-Count Prefiltered Content-Addressable Memory

This block is a small associative store. Software-facing logic writes words into numbered rows. A search then presents a key and gets back which rows hold exactly that key. The block does not compare the full key against every row at once. Each row keeps the number of 1 bits in its word, worked out when the word is written. A search first works out the number of 1 bits in the key and checks only those small counts. Only rows whose count agrees go on to the full-width data comparison. Every other row is reported as a miss, and its data comparator stays idle.

The search result is registered. It shows up one clock after the search strobe as a per-row flag vector, an any-hit flag, a multiple-hit flag and the lowest matching row index. The block also reports how many rows passed the count stage, so the amount of filtering can be observed. Rows carry a valid bit. Reset empties the store, and a row can be withdrawn by writing it with the valid input low.

Top module: `popcam_top`

## Requirements
- R1: While reset is held and after its release, `res_valid` is 0. A search of an empty store gives `hit_flags` = 0, `hit_any` = 0 and `stage2_cnt` = 0.
- R2: After row A is written with word W and `wr_valid` = 1, a search strobed with key W raises `res_valid` on the next clock. The result has bit A set in `hit_flags`, `hit_any` = 1 and `hit_addr` = A.
- R3: `stage2_cnt` equals the number of valid rows whose stored ones-count equals the key's ones-count, whether or not their data equal the key.
- R4: A row whose stored ones-count equals the key's, but whose data differ from the key, is not flagged. No row whose ones-count differs from the key's is ever flagged.
- R5: When several rows match, `hit_addr` is the lowest matching index and `hit_multi` is 1. With exactly one match, `hit_multi` is 0.
- R6: When no row matches, `hit_any`, `hit_multi`, `hit_addr` and `hit_flags` are all 0.
- R7: When a write and a search are strobed in the same cycle, the write is applied. The search result reflects the contents from before that write.
- R8: Writing a row with `wr_valid` = 0 removes it from both stages. It is neither flagged nor counted in `stage2_cnt`.
- R9: Rewriting a row replaces its word. Later searches match the new word and not the old one.
- R10: In a cycle after which no search was strobed, `res_valid` is 0 and the other result outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Row index to write |
| wr_data | input | WIDTH | Word to store |
| wr_valid | input | 1 | Valid bit stored with the word (0 withdraws the row) |
| srch_en | input | 1 | Search strobe |
| srch_key | input | WIDTH | Search key |
| res_valid | output | 1 | Result registers were loaded by a search at the last edge |
| hit_flags | output | ROWS | Per-row full-match flags |
| hit_any | output | 1 | At least one row matched |
| hit_multi | output | 1 | More than one row matched |
| hit_addr | output | AW | Lowest matching row index, 0 when none |
| stage2_cnt | output | SW | Rows that passed the ones-count stage |

## Verification
The assertions rely on three things about the inputs: the reset is asserted at start-up, the row index driven with a write is always below ROWS, and the strobes are clean levels sampled at the rising edge. The stimulus drives every input on the falling edge and only writes in-range indexes. It also uses the default power-of-two row count, so `hit_addr` can always index `hit_flags`. Keys are chosen so that several rows share a ones-count with different data, which tells the two stages apart.

// File: rtl/popcam_pkg.sv
package popcam_pkg;

    // Operation decoded from the two strobes: {search, write}
    typedef enum logic [1:0] {
        OP_IDLE   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_SEARCH = 2'b10,
        OP_BOTH   = 2'b11
    } popcam_op_e;

endpackage

// File: rtl/popcam_count.sv
// Population counter: number of set bits in a vector.
module popcam_count #(
    parameter int N  = 8,
    parameter int OW = 4
) (
    input  logic [N-1:0]  bits,
    output logic [OW-1:0] ones
);

    always_comb begin
        ones = '0;
        for (int i = 0; i < N; i++) begin
            ones = ones + OW'(bits[i]);
        end
    end

endmodule

// File: rtl/popcam_row.sv
// One storage row: word, its ones-count segment and a valid bit.
// Stage one compares the counts; stage two compares the data and
// only counts when stage one passed.
module popcam_row #(
    parameter int WIDTH = 8,
    parameter int CW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [CW-1:0]    wr_ones,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] key,
    input  logic [CW-1:0]    key_ones,
    output logic             pass1,
    output logic             hit
);

    typedef struct packed {
        logic             valid;
        logic [CW-1:0]    ones;
        logic [WIDTH-1:0] data;
    } row_t;

    row_t row_d, row_q;
    logic data_eq;

    always_comb begin
        row_d = row_q;
        if (wr_sel) begin
            row_d.valid = wr_valid;
            row_d.ones  = wr_ones;
            row_d.data  = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= '0;
        end else begin
            row_q <= row_d;
        end
    end

    // Stage one: count segment only
    assign pass1 = row_q.valid && (row_q.ones == key_ones);

    // Stage two: data comparison enabled only by stage one
    always_comb begin
        data_eq = 1'b0;
        if (pass1) begin
            data_eq = (row_q.data == key);
        end
    end

    assign hit = data_eq;

endmodule

// File: rtl/popcam_encoder.sv
// Lowest-index encoder with multiple-hit detection.
module popcam_encoder #(
    parameter int ROWS = 8,
    parameter int AW   = 3
) (
    input  logic [ROWS-1:0] flags,
    output logic            any,
    output logic            multi,
    output logic [AW-1:0]   addr
);

    always_comb begin
        any   = 1'b0;
        multi = 1'b0;
        addr  = '0;
        for (int i = 0; i < ROWS; i++) begin
            if (flags[i]) begin
                if (any) begin
                    multi = 1'b1;
                end else begin
                    any  = 1'b1;
                    addr = AW'(i);
                end
            end
        end
    end

endmodule

// File: rtl/popcam_top.sv
module popcam_top
    import popcam_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int WIDTH = 8,
    localparam int AW   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW   = $clog2(WIDTH + 1),
    localparam int SW   = $clog2(ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_valid,
    input  logic             srch_en,
    input  logic [WIDTH-1:0] srch_key,
    output logic             res_valid,
    output logic [ROWS-1:0]  hit_flags,
    output logic             hit_any,
    output logic             hit_multi,
    output logic [AW-1:0]    hit_addr,
    output logic [SW-1:0]    stage2_cnt
);

    typedef struct packed {
        logic            rvalid;
        logic [ROWS-1:0] flags;
        logic            any;
        logic            multi;
        logic [AW-1:0]   addr;
        logic [SW-1:0]   s2cnt;
    } res_t;

    popcam_op_e        op;
    logic [CW-1:0]     wr_ones;
    logic [CW-1:0]     key_ones;
    logic [ROWS-1:0]   pass1_vec;
    logic [ROWS-1:0]   hit_vec;
    logic [SW-1:0]     pass1_cnt;
    logic              enc_any;
    logic              enc_multi;
    logic [AW-1:0]     enc_addr;
    res_t              res_d, res_q;

    assign op = popcam_op_e'({srch_en, wr_en});

    // Counting segments for the incoming word and for the key
    popcam_count #(.N(WIDTH), .OW(CW)) u_wr_cnt (
        .bits (wr_data),
        .ones (wr_ones)
    );

    popcam_count #(.N(WIDTH), .OW(CW)) u_key_cnt (
        .bits (srch_key),
        .ones (key_ones)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic sel;
        assign sel = (op == OP_WRITE || op == OP_BOTH) && (wr_addr == AW'(r));

        popcam_row #(.WIDTH(WIDTH), .CW(CW)) u_row (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (sel),
            .wr_data  (wr_data),
            .wr_ones  (wr_ones),
            .wr_valid (wr_valid),
            .key      (srch_key),
            .key_ones (key_ones),
            .pass1    (pass1_vec[r]),
            .hit      (hit_vec[r])
        );
    end

    popcam_count #(.N(ROWS), .OW(SW)) u_s2_cnt (
        .bits (pass1_vec),
        .ones (pass1_cnt)
    );

    popcam_encoder #(.ROWS(ROWS), .AW(AW)) u_enc (
        .flags (hit_vec),
        .any   (enc_any),
        .multi (enc_multi),
        .addr  (enc_addr)
    );

    always_comb begin
        res_d        = res_q;
        res_d.rvalid = 1'b0;
        if (op == OP_SEARCH || op == OP_BOTH) begin
            res_d.rvalid = 1'b1;
            res_d.flags  = hit_vec;
            res_d.any    = enc_any;
            res_d.multi  = enc_multi;
            res_d.addr   = enc_addr;
            res_d.s2cnt  = pass1_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid  = res_q.rvalid;
    assign hit_flags  = res_q.flags;
    assign hit_any    = res_q.any;
    assign hit_multi  = res_q.multi;
    assign hit_addr   = res_q.addr;
    assign stage2_cnt = res_q.s2cnt;

endmodule

// File: rtl/popcam_chk.sv
module popcam_chk #(
    parameter int ROWS = 8,
    parameter int AW   = 3,
    parameter int SW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            srch_en,
    input logic            res_valid,
    input logic [ROWS-1:0] hit_flags,
    input logic            hit_any,
    input logic            hit_multi,
    input logic [AW-1:0]   hit_addr,
    input logic [SW-1:0]   stage2_cnt
);

    // R2
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |=> res_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> (!res_valid && $stable(hit_flags) && $stable(hit_addr)
                      && $stable(stage2_cnt)));

    // R3
    filter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones(hit_flags) <= int'(stage2_cnt)));

    // R5
    multi_needs_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_multi |-> ($countones(hit_flags) > 1));

    // R5
    addr_points_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> hit_flags[hit_addr]);

    // R6
    miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_any |-> (hit_flags == '0 && hit_addr == '0 && !hit_multi));

endmodule

bind popcam_top popcam_chk #(.ROWS(ROWS), .AW(AW), .SW(SW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .srch_en    (srch_en),
    .res_valid  (res_valid),
    .hit_flags  (hit_flags),
    .hit_any    (hit_any),
    .hit_multi  (hit_multi),
    .hit_addr   (hit_addr),
    .stage2_cnt (stage2_cnt)
);

// File: tb/popcam_top_bench.sv
`timescale 1ns/1ps
module popcam_top_bench;

    localparam int ROWS  = 8;
    localparam int WIDTH = 8;
    localparam int AW    = 3;
    localparam int SW    = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [AW-1:0]    wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             wr_valid = 1'b0;
    logic             srch_en = 1'b0;
    logic [WIDTH-1:0] srch_key = '0;
    logic             res_valid;
    logic [ROWS-1:0]  hit_flags;
    logic             hit_any;
    logic             hit_multi;
    logic [AW-1:0]    hit_addr;
    logic [SW-1:0]    stage2_cnt;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [WIDTH-1:0] m_data [ROWS];
    logic             m_val  [ROWS];

    logic [ROWS-1:0]  e_flags;
    int               e_s2;
    int               e_addr;
    logic             e_any;
    logic             e_multi;

    always #2.5 clk = ~clk;

    popcam_top #(.ROWS(ROWS), .WIDTH(WIDTH)) u_popcam_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_valid   (wr_valid),
        .srch_en    (srch_en),
        .srch_key   (srch_key),
        .res_valid  (res_valid),
        .hit_flags  (hit_flags),
        .hit_any    (hit_any),
        .hit_multi  (hit_multi),
        .hit_addr   (hit_addr),
        .stage2_cnt (stage2_cnt)
    );

    task automatic chk(string req, string what, int got, int exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // Expected result from the requirements and the bench's own row model
    task automatic expect_for(logic [WIDTH-1:0] key);
        int n;
        e_flags = '0;
        e_s2    = 0;
        n       = 0;
        e_addr  = 0;
        for (int r = 0; r < ROWS; r++) begin
            if (m_val[r] && ($countones(m_data[r]) == $countones(key))) begin
                e_s2++;
            end
            if (m_val[r] && m_data[r] == key) begin
                if (n == 0) e_addr = r;
                e_flags[r] = 1'b1;
                n++;
            end
        end
        e_any   = (n > 0);
        e_multi = (n > 1);
    endtask

    task automatic check_result(string req);
        chk(req, "res_valid", int'(res_valid), 1);
        chk(req, "hit_flags", int'(hit_flags), int'(e_flags));
        chk(req, "hit_any", int'(hit_any), int'(e_any));
        chk(req, "hit_multi", int'(hit_multi), int'(e_multi));
        chk(req, "hit_addr", int'(hit_addr), e_addr);
        chk(req, "stage2_cnt", int'(stage2_cnt), e_s2);
    endtask

    task automatic do_write(int a, logic [WIDTH-1:0] d, logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
        m_data[a] = d;
        m_val[a]  = v;
    endtask

    task automatic do_search(logic [WIDTH-1:0] key, string req);
        expect_for(key);
        @(negedge clk);
        srch_en = 1'b1; srch_key = key;
        @(negedge clk);
        srch_en = 1'b0;
        check_result(req);
    endtask

    task automatic t_reset();
        for (int r = 0; r < ROWS; r++) begin
            m_data[r] = '0;
            m_val[r]  = 1'b0;
        end
        repeat (3) @(negedge clk);
        chk("R1", "res_valid in reset", int'(res_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "res_valid after reset", int'(res_valid), 0);
        do_search(8'h00, "R1");
        chk("R1", "empty stage2_cnt", int'(stage2_cnt), 0);
    endtask

    task automatic t_basic();
        do_write(3, 8'hA5, 1'b1);
        do_search(8'hA5, "R2");
        chk("R2", "addr of single hit", int'(hit_addr), 3);
    endtask

    task automatic t_filter();
        do_write(0, 8'h0F, 1'b1);
        do_write(1, 8'hF0, 1'b1);
        do_write(2, 8'h01, 1'b1);
        // 0x3C has four ones like rows 0, 1, 3 but equals none of them
        do_search(8'h3C, "R3");
        chk("R3", "count-stage passes", int'(stage2_cnt), 3);
        chk("R4", "same count, different data", int'(hit_flags), 0);
        chk("R6", "miss any", int'(hit_any), 0);
        do_search(8'h01, "R4");
        chk("R4", "only row 2 hit", int'(hit_flags), 4);
    endtask

    task automatic t_multi();
        do_write(5, 8'h0F, 1'b1);
        do_search(8'h0F, "R5");
        chk("R5", "lowest index", int'(hit_addr), 0);
        chk("R5", "multi flag", int'(hit_multi), 1);
    endtask

    task automatic t_collide();
        // Row 2 holds 0x01; rewrite it to 0x77 while searching 0x77
        expect_for(8'h77);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h77; wr_valid = 1'b1;
        srch_en = 1'b1; srch_key = 8'h77;
        @(negedge clk);
        wr_en = 1'b0; srch_en = 1'b0;
        m_data[2] = 8'h77; m_val[2] = 1'b1;
        check_result("R7");
        chk("R7", "old contents seen", int'(hit_any), 0);
        do_search(8'h77, "R9");
        chk("R9", "new word found", int'(hit_addr), 2);
        do_search(8'h01, "R9");
        chk("R9", "old word gone", int'(hit_any), 0);
    endtask

    task automatic t_invalidate();
        do_write(0, 8'h0F, 1'b0);
        do_search(8'h0F, "R8");
        chk("R8", "only row 5 left", int'(hit_flags), 32);
        chk("R8", "single hit", int'(hit_multi), 0);
        chk("R8", "count excludes invalid", int'(stage2_cnt), 3);
    endtask

    task automatic t_idle();
        do_search(8'hA5, "R10");
        @(negedge clk);
        chk("R10", "res_valid drops", int'(res_valid), 0);
        chk("R10", "flags held", int'(hit_flags), int'(e_flags));
        chk("R10", "addr held", int'(hit_addr), e_addr);
        chk("R10", "count held", int'(stage2_cnt), e_s2);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_filter();
        t_multi();
        t_collide();
        t_invalidate();
        t_idle();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule